// File: doc/BRIEF.md
# DShot Motor Command Serializer

This block turns one motor command into a DShot frame and sends it on a single output line. A start strobe carries an 11-bit command and a telemetry-request flag. The block places the flag below the command to form a 12-bit payload. It computes a 4-bit checksum by XOR-ing the payload's three nibbles and appends it to make a 16-bit frame. Each frame bit is sent as a fixed-length cell. The line goes high at the start of the cell and stays high for a short time for a 0 or a long time for a 1. Two all-low cells follow the data as a reset gap.

The cell length and both high times are parameters. At a 108 MHz tick, the defaults of 180, 60 and 120 ticks give the 600 kbit/s rate. Scaling these counts gives the slower rates. Several instances can share one start strobe, one per motor. Because each instance latches its inputs on the same edge and runs the same counters, every motor line starts its frame on the same clock edge.

Top module: `dshot_tx`

## Requirements
- R1: Every bit cell lasts exactly CELL_TICKS clock cycles. The line rises only on the first cycle of a data cell, so consecutive rising edges within a frame are CELL_TICKS cycles apart.
- R2: In a data cell the line is high for ZERO_HIGH cycles when the bit is 0 and for ONE_HIGH cycles when the bit is 1. It is low for the rest of the cell.
- R3: Frame bits 15 down to 4 hold the payload. The payload is the 11-bit command in its bits 11..1 and the telemetry-request flag in its bit 0.
- R4: Frame bits 3..0 hold the checksum. The checksum is payload[11:8] XOR payload[7:4] XOR payload[3:0].
- R5: The 16 frame bits are sent in order from bit 15 to bit 0.
- R6: After the 16 data cells, the line stays low for two more full cells. The busy flag is high for exactly 18 × CELL_TICKS cycles, starting on the cycle after the accepting edge.
- R7: A start strobe is accepted only while busy is low. The command and flag are captured on that edge. A strobe during a frame, or a change to the command or flag during a frame, does not change the frame and does not start another one.
- R8: After reset and whenever busy is low, the line is low.
- R9: Command values below 48 are sent unchanged, exactly like throttle values.
- R10: Instances that share one start strobe raise their lines on the same cycles and keep their busy flags equal, whatever commands they carry.
- R11: With the cell length and both high times scaled down, the waveform follows the same rules using the new counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send a frame; accepted when idle |
| cmd | input | 11 | Motor command value |
| telem_req | input | 1 | Telemetry-request flag placed in the payload's lowest bit |
| line | output | 1 | Serial pulse-width-coded output |
| busy | output | 1 | High from the acceptance of a start until the end of the reset gap |

## Verification
The embedded assertions check the rules that hold on every cycle. The line is low whenever busy is low and during the two gap cells. High time never exceeds the long pulse. Rising edges occur only at the first tick of a cell. The captured frame stays frozen inside a cell, and busy drops right after the last gap tick. Only the bench's scenarios can show the frame contents: the payload layout, the checksum value, the MSB-first order, reserved commands passing through unchanged, a strobe in the middle of a frame being ignored, and lockstep between instances that share a strobe. For these the bench decodes the pulse widths back into bits and compares every cycle with a queue-based model.

// File: rtl/dshot_tx.sv
module dshot_tx #(
  parameter int CELL_TICKS = 180,
  parameter int ZERO_HIGH  = 60,
  parameter int ONE_HIGH   = 120,
  parameter int GAP_CELLS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [10:0] cmd,
  input  logic        telem_req,
  output logic        line,
  output logic        busy
);
  localparam int FRAME_BITS = 16;
  localparam int SLOTS      = FRAME_BITS + GAP_CELLS;
  localparam int TW         = $clog2(CELL_TICKS);
  localparam int SW         = $clog2(SLOTS);
  localparam logic [TW-1:0] LAST_TICK = TW'(CELL_TICKS - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [SW-1:0] DATA_END  = SW'(FRAME_BITS);

  logic [11:0] payload;
  logic [3:0]  csum;
  logic [15:0] shreg;
  logic [TW-1:0] tick;
  logic [SW-1:0] slot;
  logic          busy_q;
  logic [TW-1:0] high_ticks;

  assign payload    = {cmd, telem_req};
  assign csum       = payload[11:8] ^ payload[7:4] ^ payload[3:0];
  assign high_ticks = shreg[15] ? TW'(ONE_HIGH) : TW'(ZERO_HIGH);
  assign busy       = busy_q;
  assign line       = busy_q && (slot < DATA_END) && (tick < high_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick   <= '0;
      slot   <= '0;
      shreg  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        tick   <= '0;
        slot   <= '0;
        shreg  <= {payload, csum};
      end
    end else if (tick == LAST_TICK) begin
      tick  <= '0;
      shreg <= {shreg[14:0], 1'b0};
      if (slot == LAST_SLOT) begin
        busy_q <= 1'b0;
        slot   <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end else begin
      tick <= tick + 1'b1;
    end
  end

  initial begin
    assert (ZERO_HIGH > 0 && ZERO_HIGH < ONE_HIGH && ONE_HIGH < CELL_TICKS); // R2
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line); // R8
  AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot >= DATA_END) |-> !line); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == LAST_SLOT && tick == LAST_TICK) |=> !busy); // R6
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick != LAST_TICK) |=> $stable(shreg)); // R7
  AST_RISE_AT_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> (tick == '0)); // R1
  AST_HIGH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    line |-> (tick < TW'(ONE_HIGH))); // R2
endmodule

// File: tb/test_dshot_tx.sv
module ref_dshot #(
  parameter int CELL = 180,
  parameter int T0   = 60,
  parameter int T1   = 120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [10:0] cmd,
  input  logic        telem,
  output logic        exp_line,
  output logic        exp_busy
);
  bit q[$];

  function automatic logic [15:0] make_frame(logic [10:0] c, logic t);
    int p, cs;
    p  = (int'(c) << 1) | int'(t);
    cs = 0;
    for (int i = 0; i < 3; i++) cs = cs ^ ((p >> (4 * i)) & 15);
    return 16'((p << 4) | cs);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_line = 1'b0;
      exp_busy = 1'b0;
    end else begin
      if (!exp_busy && start) begin
        logic [15:0] f;
        f = make_frame(cmd, telem);
        for (int s = 0; s < 18; s++)
          for (int t = 0; t < CELL; t++)
            q.push_back((s < 16) && (t < (f[15 - s] ? T1 : T0)));
      end
      if (q.size() > 0) begin
        exp_line = q.pop_front();
        exp_busy = 1'b1;
      end else begin
        exp_line = 1'b0;
        exp_busy = 1'b0;
      end
    end
  end
endmodule

module test_dshot_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10:0] cmd = '0, cmd_b = '0;
  logic telem = 1'b0, telem_b = 1'b0;
  logic line_a, busy_a, line_b, busy_b, line_s, busy_s;
  logic el_a, eb_a, el_b, eb_b, el_s, eb_s;

  always #2 clk = ~clk;

  dshot_tx i_dshot_tx (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .telem_req(telem), .line(line_a), .busy(busy_a));
  dshot_tx i_dshot_tx_peer (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_b),
    .telem_req(telem_b), .line(line_b), .busy(busy_b));
  dshot_tx #(.CELL_TICKS(12), .ZERO_HIGH(4), .ONE_HIGH(8)) i_dshot_tx_slow (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .telem_req(telem),
    .line(line_s), .busy(busy_s));

  ref_dshot #(180, 60, 120) m_a (clk, rst_n, start, cmd, telem, el_a, eb_a);
  ref_dshot #(180, 60, 120) m_b (clk, rst_n, start, cmd_b, telem_b, el_b, eb_b);
  ref_dshot #(12, 4, 8)     m_s (clk, rst_n, start, cmd, telem, el_s, eb_s);

  int checks = 0, fails = 0, cyc = 0;
  int run = 0, nbits = 0, bcount = 0, last_rise = -1, frames = 0;
  logic [15:0] dec = '0, last_dec = '0;
  int last_nbits = 0;
  logic pa = 1'b0, pb = 1'b0, pla = 1'b0, plb = 1'b0;

  function automatic logic [15:0] frame_of(logic [10:0] c, logic t);
    logic [11:0] p;
    logic [3:0] cs;
    p = {c, t};
    cs = 4'(p >> 8) ^ 4'(p >> 4) ^ 4'(p);
    return {p, cs};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, expv, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      chk(line_a == el_a, "R2", "line main", int'(line_a), int'(el_a));
      chk(busy_a == eb_a, "R6", "busy main", int'(busy_a), int'(eb_a));
      chk(line_b == el_b, "R2", "line peer", int'(line_b), int'(el_b));
      chk(line_s == el_s, "R11", "line scaled", int'(line_s), int'(el_s));
      chk(busy_s == eb_s, "R11", "busy scaled", int'(busy_s), int'(eb_s));
      chk(busy_a == busy_b, "R10", "busy lockstep", int'(busy_b), int'(busy_a));
      chk((line_a && !pla) == (line_b && !plb), "R10", "rise lockstep",
          int'(line_b && !plb), int'(line_a && !pla));
      if (!busy_a) chk(!line_a, "R8", "idle line", int'(line_a), 0);
      if (busy_a && !pa) begin
        last_rise = -1; nbits = 0; dec = '0; bcount = 0;
      end
      if (busy_a) bcount++;
      if (line_a && !pla) begin
        if (last_rise >= 0) chk(cyc - last_rise == 180, "R1", "cell spacing", cyc - last_rise, 180);
        last_rise = cyc;
      end
      if (line_a) run++;
      else if (pla) begin
        chk(run == 60 || run == 120, "R2", "high width", run, 60);
        dec = {dec[14:0], run == 120};
        nbits++;
        run = 0;
      end
      if (pa && !busy_a) begin
        chk(bcount == 18 * 180, "R6", "busy length", bcount, 18 * 180);
        last_dec = dec; last_nbits = nbits; frames++;
      end
    end
    pa = busy_a; pla = line_a; plb = line_b;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input logic [10:0] c, input logic t, input logic [10:0] cb,
                      input logic tb, input bit disturb, input string req);
    int f0;
    f0 = frames;
    @(negedge clk);
    cmd = c; telem = t; cmd_b = cb; telem_b = tb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (500) @(negedge clk);
      cmd = ~c; telem = ~t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000 && frames == f0; i++) @(negedge clk);
    chk(last_nbits == 16, "R5", {req, " bit count"}, last_nbits, 16);
    chk(last_dec[15:4] == {c, t}, "R3", {req, " payload"}, int'(last_dec[15:4]), int'({c, t}));
    chk(last_dec[3:0] == frame_of(c, t)[3:0], "R4", {req, " checksum"},
        int'(last_dec[3:0]), int'(frame_of(c, t)[3:0]));
    chk(last_dec == frame_of(c, t), "R5", {req, " msb first frame"},
        int'(last_dec), int'(frame_of(c, t)));
    repeat (20) @(negedge clk);
    chk(!busy_a && !line_a, "R7", {req, " no extra frame"}, int'(busy_a), 0);
    cmd = c; telem = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!line_a && !busy_a, "R8", "reset line", int'(line_a | busy_a), 0);
    chk(!line_s && !busy_s, "R8", "reset scaled", int'(line_s | busy_s), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    send(11'd0, 1'b0, 11'd2047, 1'b1, 1'b0, "R9 zero");
    send(11'd47, 1'b1, 11'd48, 1'b0, 1'b0, "R9 reserved");
    send(11'd48, 1'b0, 11'd0, 1'b0, 1'b0, "R3 min throttle");
    send(11'd2047, 1'b1, 11'd1000, 1'b1, 1'b0, "R4 max throttle");
    send(11'h555, 1'b0, 11'h2AA, 1'b1, 1'b0, "R5 alternating");
    send(11'd1046, 1'b1, 11'd3, 1'b0, 1'b1, "R7 mid-frame strobe");
    send(11'h3C3, 1'b0, 11'h13, 1'b0, 1'b0, "R10 after disturb");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule